// File: doc/BRIEF.md
# Converter Clock and Start Controller

This block is the control front end of a shared analog converter that runs either as an ADC or as a DAC. It produces the converter clock from one of two sources. The first is a fixed 2 MHz clock made by dividing an 8 MHz oscillator by four. The second is the system clock divided by a power of two, chosen from seven prescaler stages. Selecting the fixed source forces the oscillator's enable on.

Conversions start in one of two ways. Software can write the busy bit, or an overflow on one selected timer can start a conversion, and every such overflow starts a new one. Once a conversion starts, the busy status stays set until the converter core returns a done pulse. Completion then produces a one-cycle done strobe and sets a sticky interrupt flag. A start request that arrives while a conversion is running is dropped and sets a sticky overrun flag. The channel number is captured at the start of each conversion, and channel writes are refused while busy.

In DAC mode the block raises a configuration error flag whenever the chosen converter clock is faster than the CPU clock. The CPU clock is the system clock divided by 2^`cpu_div_i`, and the system clock is 16 MHz by parameter.

Top module: `cnv_ctrl`

## Requirements
- R1: With clock code c in 0..6 (control register, address 0, bits 2:0), `conv_clk_o` is the system clock divided by 2^(c+1), so it shows exactly 256/2^(c+1) rising edges over any 256 system cycles.
- R2: Clock code 7 makes `conv_clk_o` the oscillator divided by 4 (2 MHz from 8 MHz) and forces `osc_en_o` to 1. For other codes, `osc_en_o` follows `osc_req_i`.
- R3: A write to address 0 with bit 7 (enable) and bit 6 (start) both set starts a conversion. On the next cycle `busy_o` is 1 and `start_o` is 1 for exactly one cycle.
- R4: A start write with bit 7 clear is ignored. While the stored enable is 0, timer overflows are also ignored: `busy_o` and `start_o` stay 0.
- R5: `busy_o` stays 1 until `done_i` is seen while busy. It clears on the next cycle, and `done_o` pulses for that one cycle. Writing 0 to bit 6 does not clear busy.
- R6: The trigger select (address 1, bits 2:0) value k in 1..4 makes every pulse on `ovf_i[k-1]` start a conversion when idle. Value 0, or pulses on the other lines, start nothing.
- R7: A software start or a selected overflow that arrives while busy starts nothing and sets `ovr_o`. `ovr_o` stays set until a write of 1 to address 2, bit 1.
- R8: `conv_chan_o` takes the staged channel (address 1, bits 6:4) at each start. Channel writes made while busy are discarded.
- R9: `irq_o` is set on completion and stays set until a write of 1 to address 2, bit 0. A write to bit 1 alone leaves it set.
- R10: With bit 5 of address 0 set (DAC mode), `cfg_err_o` is 1 when c+1 < `cpu_div_i` for codes 0..6, or when 2000 kHz exceeds 16000 kHz / 2^`cpu_div_i` for code 7. In ADC mode it is always 0, and `dac_mode_o` mirrors bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_clk_i | input | 1 | 8 MHz internal oscillator |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 control, 1 config, 2 flag clear) |
| wr_data_i | input | 8 | Register write data |
| cpu_div_i | input | 3 | CPU clock divide exponent |
| osc_req_i | input | 1 | Oscillator request from the clock system |
| ovf_i | input | N_TRIG | Timer overflow pulses |
| done_i | input | 1 | Conversion complete from converter core |
| conv_clk_o | output | 1 | Converter clock |
| osc_en_o | output | 1 | Oscillator enable |
| start_o | output | 1 | One-cycle start to converter core |
| conv_chan_o | output | CHAN_W | Channel latched for current conversion |
| dac_mode_o | output | 1 | DAC mode selected |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion strobe |
| irq_o | output | 1 | Sticky completion interrupt |
| ovr_o | output | 1 | Sticky dropped-start flag |
| cfg_err_o | output | 1 | DAC clock faster than CPU clock |

## Verification
The bench sweeps all eight clock codes and counts clock edges over whole prescaler periods. An off-by-one in the divider exponent would change every count by a factor of two. It also sweeps all 128 combinations of mode, clock code and CPU divider against the DAC rule, so a check that used the wrong side of the boundary shows up exactly at c+1 = `cpu_div_i`. Each timer line is pulsed under each trigger select, which exposes a mux that is shifted by one or that ignores select 0. A fixed-latency responder times busy to the cycle. Repeated starts while busy must leave the channel and busy untouched and set overrun; a design that restarts or re-latches would change `conv_chan_o` or shorten the busy window.

// File: rtl/cnv_pkg.sv
package cnv_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;
  localparam int EN_B  = 7;
  localparam int GO_B  = 6;
  localparam int DAC_B = 5;
  localparam int CHAN_LSB = 4;
  localparam logic [2:0] CLK_INT = 3'd7;

  typedef struct packed {
    logic       en;
    logic       dac;
    logic [2:0] clk_sel;
  } ctrl_t;
endpackage

// File: rtl/cnv_clkgen.sv
module cnv_clkgen import cnv_pkg::*; #(
  parameter int PRE_W = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_clk_i,
  input  logic [2:0] clk_sel_i,
  input  logic       osc_req_i,
  output logic       conv_clk_o,
  output logic       osc_en_o
);
  logic [PRE_W-1:0] pre_q;
  logic [1:0]       osc_q;
  logic             use_int;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;

  // fixed divide-by-4 in oscillator domain
  always_ff @(posedge osc_clk_i or negedge rst_ni)
    if (!rst_ni) osc_q <= '0;
    else         osc_q <= osc_q + 1'b1;

  assign use_int    = (clk_sel_i == CLK_INT);
  assign conv_clk_o = use_int ? osc_q[1] : pre_q[clk_sel_i];
  assign osc_en_o   = use_int | osc_req_i;
endmodule

// File: rtl/cnv_trig.sv
module cnv_trig #(
  parameter int N_TRIG = 4,
  parameter int TSEL_W = 3
) (
  input  logic [N_TRIG-1:0] ovf_i,
  input  logic [TSEL_W-1:0] sel_i,
  output logic              hit_o
);
  logic [N_TRIG-1:0] hit_v;

  // select 0 = no timer source
  for (genvar g = 0; g < N_TRIG; g++) begin : g_line
    assign hit_v[g] = ovf_i[g] && (sel_i == TSEL_W'(g + 1));
  end

  assign hit_o = |hit_v;
endmodule

// File: rtl/cnv_seq.sv
module cnv_seq #(
  parameter int CHAN_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              done_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              irq_clr_i,
  input  logic              ovr_clr_i,
  output logic              busy_o,
  output logic              start_o,
  output logic              done_o,
  output logic              irq_o,
  output logic              ovr_o,
  output logic [CHAN_W-1:0] chan_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      start_o <= 1'b0;
      done_o  <= 1'b0;
      irq_o   <= 1'b0;
      ovr_o   <= 1'b0;
      chan_o  <= '0;
    end else begin
      start_o <= 1'b0;
      done_o  <= 1'b0;
      if (irq_clr_i) irq_o <= 1'b0;
      if (ovr_clr_i) ovr_o <= 1'b0;
      if (busy_o) begin
        if (done_i) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          irq_o  <= 1'b1;
        end
        // late requests are dropped, set wins over clear
        if (req_i) ovr_o <= 1'b1;
      end else if (req_i) begin
        busy_o  <= 1'b1;
        start_o <= 1'b1;
        chan_o  <= chan_i;
      end
    end
  end
endmodule

// File: rtl/cnv_ctrl.sv
module cnv_ctrl import cnv_pkg::*; #(
  parameter int N_TRIG  = 4,
  parameter int CHAN_W  = 3,
  parameter int PRE_W   = 7,
  parameter int SYS_KHZ = 16000,
  parameter int INT_KHZ = 2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_clk_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [2:0]        cpu_div_i,
  input  logic              osc_req_i,
  input  logic [N_TRIG-1:0] ovf_i,
  input  logic              done_i,
  output logic              conv_clk_o,
  output logic              osc_en_o,
  output logic              start_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  output logic              dac_mode_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o,
  output logic              ovr_o,
  output logic              cfg_err_o
);
  localparam int TSEL_W = $clog2(N_TRIG + 1);

  ctrl_t             ctrl_q;
  logic [TSEL_W-1:0] tsel_q;
  logic [CHAN_W-1:0] chan_q;
  logic [2:0]        clk_sel;
  logic              wr_ctrl, wr_cfg, wr_flag;
  logic              sw_go, hit, req;
  logic              unused_wd;

  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_cfg  = wr_en_i && (wr_addr_i == ADDR_CFG);
  assign wr_flag = wr_en_i && (wr_addr_i == ADDR_FLAG);
  assign unused_wd = wr_data_i[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tsel_q <= '0;
      chan_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en      <= wr_data_i[EN_B];
        ctrl_q.dac     <= wr_data_i[DAC_B];
        ctrl_q.clk_sel <= wr_data_i[2:0];
      end
      if (wr_cfg) begin
        tsel_q <= wr_data_i[TSEL_W-1:0];
        if (!busy_o) chan_q <= wr_data_i[CHAN_LSB +: CHAN_W];
      end
    end
  end

  assign clk_sel    = ctrl_q.clk_sel;
  assign dac_mode_o = ctrl_q.dac;
  // software start uses the enable carried by the same write
  assign sw_go = wr_ctrl && wr_data_i[EN_B] && wr_data_i[GO_B];
  assign req   = sw_go || (ctrl_q.en && hit);

  always_comb begin
    cfg_err_o = 1'b0;
    if (ctrl_q.dac) begin
      if (clk_sel == CLK_INT)
        cfg_err_o = (32'(INT_KHZ) << cpu_div_i) > 32'(SYS_KHZ);
      else
        cfg_err_o = ({1'b0, clk_sel} + 4'd1) < {1'b0, cpu_div_i};
    end
  end

  cnv_clkgen #(.PRE_W(PRE_W)) u_clkgen (
    .clk_i, .rst_ni, .osc_clk_i,
    .clk_sel_i (clk_sel),
    .osc_req_i,
    .conv_clk_o,
    .osc_en_o
  );

  cnv_trig #(.N_TRIG(N_TRIG), .TSEL_W(TSEL_W)) u_trig (
    .ovf_i,
    .sel_i (tsel_q),
    .hit_o (hit)
  );

  cnv_seq #(.CHAN_W(CHAN_W)) u_seq (
    .clk_i, .rst_ni,
    .req_i     (req),
    .done_i,
    .chan_i    (chan_q),
    .irq_clr_i (wr_flag && wr_data_i[0]),
    .ovr_clr_i (wr_flag && wr_data_i[1]),
    .busy_o, .start_o, .done_o, .irq_o, .ovr_o,
    .chan_o    (conv_chan_o)
  );
endmodule

// File: rtl/cnv_ctrl_chk.sv
module cnv_ctrl_chk #(
  parameter int CHAN_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        clk_sel_i,
  input logic              osc_en_o,
  input logic              start_o,
  input logic              busy_o,
  input logic              done_i,
  input logic              done_o,
  input logic              irq_o,
  input logic [CHAN_W-1:0] conv_chan_o
);
  // R2
  osc_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_sel_i == 3'd7 |-> osc_en_o);
  // R3
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R3
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> start_o);
  // R7
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !$past(busy_o));
  // R5
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && done_i |=> !busy_o && done_o);
  // R9
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> irq_o);
  // R8
  chan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !start_o |-> $stable(conv_chan_o));
endmodule

bind cnv_ctrl cnv_ctrl_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk_i, .rst_ni,
  .clk_sel_i (clk_sel),
  .osc_en_o, .start_o, .busy_o, .done_i, .done_o, .irq_o, .conv_chan_o
);

// File: tb/cnv_ctrl_test.sv
module cnv_ctrl_test;
  localparam int LAT = 5;

  logic       clk = 1'b0, osc = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] cpu_div = '0;
  logic       osc_req = 1'b0;
  logic [3:0] ovf = '0;
  logic       done_i;
  logic       conv_clk, osc_en, start, dac_mode, busy, done_o, irq, ovr, cfg_err;
  logic [2:0] chan;
  int n_chk = 0, n_bad = 0;
  int rcnt;

  always #5ns clk = ~clk;
  always #62.5ns osc = ~osc;

  cnv_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .osc_clk_i(osc),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cpu_div_i(cpu_div), .osc_req_i(osc_req), .ovf_i(ovf), .done_i(done_i),
    .conv_clk_o(conv_clk), .osc_en_o(osc_en), .start_o(start),
    .conv_chan_o(chan), .dac_mode_o(dac_mode), .busy_o(busy),
    .done_o(done_o), .irq_o(irq), .ovr_o(ovr), .cfg_err_o(cfg_err)
  );

  // converter core model: done LAT cycles after start
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= 0; done_i <= 1'b0;
    end else begin
      done_i <= (rcnt == 1);
      if (start) rcnt <= LAT;
      else if (rcnt != 0) rcnt <= rcnt - 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input int line);
    @(negedge clk); ovf = 4'(1 << line);
    @(negedge clk); ovf = '0;
  endtask

  task automatic wait_done(output int k, output int busy_gap);
    k = 0; busy_gap = 0;
    while (!done_o && k < 50) begin
      if (!busy) busy_gap = 1;
      @(negedge clk); k++;
    end
  endtask

  task automatic edges(input int n, output int cnt);
    logic prev;
    cnt = 0; prev = conv_clk;
    repeat (n) begin
      @(negedge clk);
      if (!prev && conv_clk) cnt++;
      prev = conv_clk;
    end
  endtask

  initial begin
    #1ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k, gap, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset busy", busy, 0);
    chk("reset irq", irq, 0);
    chk("reset ovr", ovr, 0);
    chk("reset start", start, 0);

    // R1 prescaler sweep, R2 oscillator source
    for (int c = 0; c < 7; c++) begin
      wr(2'd0, 8'(c));
      edges(256, cnt);
      chk($sformatf("R1 code %0d edges", c), cnt, 256 >> (c + 1));
      chk("R2 osc_en off", osc_en, 0);
    end
    osc_req = 1'b1; @(negedge clk);
    chk("R2 osc_en follows request", osc_en, 1);
    osc_req = 1'b0;
    wr(2'd0, 8'h07);
    chk("R2 osc_en forced", osc_en, 1);
    edges(400, cnt);
    chk("R2 internal 2MHz edges", cnt, 8);

    // R10 DAC clock rule sweep
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < 8; c++)
        for (int cd = 0; cd < 8; cd++) begin
          int exp;
          cpu_div = 3'(cd);
          wr(2'd0, 8'((d << 5) | c));
          if (d == 0) exp = 0;
          else if (c == 7) exp = ((2000 << cd) > 16000) ? 1 : 0;
          else exp = (c + 1 < cd) ? 1 : 0;
          chk($sformatf("R10 dac=%0d c=%0d div=%0d", d, c, cd), cfg_err, exp);
          chk("R10 mode mirror", dac_mode, d);
        end
    cpu_div = '0;

    // R4 disabled start ignored
    wr(2'd0, 8'h40);
    chk("R4 go without enable busy", busy, 0);
    chk("R4 go without enable start", start, 0);
    wr(2'd1, 8'h01);
    pulse(0);
    chk("R4 overflow while disabled", start, 0);

    // R3 / R5 / R8 software start with channel
    wr(2'd1, 8'h50);
    wr(2'd0, 8'hC0);
    chk("R3 start pulse", start, 1);
    chk("R3 busy set", busy, 1);
    chk("R8 channel latched", chan, 5);
    @(negedge clk);
    chk("R3 start one cycle", start, 0);
    wr(2'd0, 8'h80);
    chk("R5 write 0 keeps busy", busy, 1);
    wr(2'd1, 8'h20);
    chk("R8 channel held while busy", chan, 5);
    wait_done(k, gap);
    chk("R5 busy gap", gap, 0);
    chk("R5 busy cleared", busy, 0);
    chk("R9 irq set", irq, 1);
    @(negedge clk);
    chk("R5 done one cycle", done_o, 0);
    wr(2'd0, 8'hC0);
    chk("R8 blocked write discarded", chan, 5);
    wait_done(k, gap);
    chk("R5 exact latency", k, LAT + 2);
    @(negedge clk);
    wr(2'd1, 8'h20);
    wr(2'd0, 8'hC0);
    chk("R8 idle write taken", chan, 2);

    // R7 overrun
    wr(2'd0, 8'hC0);
    chk("R7 no restart", start, 0);
    chk("R7 overrun set", ovr, 1);
    chk("R7 chan kept", chan, 2);
    wait_done(k, gap);
    @(negedge clk);

    // R9 / R7 clear
    wr(2'd2, 8'h02);
    chk("R7 overrun cleared", ovr, 0);
    chk("R9 irq survives other clear", irq, 1);
    wr(2'd2, 8'h01);
    chk("R9 irq cleared", irq, 0);

    // R6 trigger select sweep
    for (int s = 0; s < 5; s++) begin
      wr(2'd1, 8'(s));
      for (int j = 0; j < 4; j++) begin
        pulse(j);
        chk($sformatf("R6 sel=%0d line=%0d", s, j), start, (s == j + 1) ? 1 : 0);
        if (start) begin wait_done(k, gap); @(negedge clk); end
      end
    end
    wr(2'd1, 8'h03);
    for (int r = 0; r < 3; r++) begin
      pulse(2);
      chk("R6 every overflow starts", start, 1);
      wait_done(k, gap);
      @(negedge clk);
    end
    wr(2'd2, 8'h03);
    pulse(2);
    pulse(2);
    chk("R7 overflow while busy", ovr, 1);
    wait_done(k, gap);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule